// File: doc/BRIEF.md
# Modulo-6 Synchronous State Counter

This block is a free-running counter that cycles through the values 0 to 5 and then back to 0. It advances once on every rising clock edge. The count is held as a three-bit state in three D flip-flops. A purely combinational next-state function feeds those flip-flops. The two codes that the count never uses (6 and 7) still have a defined successor, so a disturbed counter rejoins the legal sequence after a single clock.

The named states are ZERO, ONE, TWO, THREE, FOUR and FIVE, plus the unused codes SPARE6 and SPARE7. The transitions are:

- ZERO→ONE, ONE→TWO, TWO→THREE, THREE→FOUR and FOUR→FIVE (the step transitions).
- FIVE→ZERO (the wrap transition).
- SPARE6→ONE and SPARE7→ZERO (the recovery transitions).

In every state the low bit of the next code is the complement of the current low bit. A `wrap` output is high for exactly the cycle in which the count shows FIVE. It lets a neighbouring block divide the clock by six. A synchronous active-high reset loads the parameter `RESET_CODE`, whose default is ZERO.

Top module: `modsix_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count loads `RESET_CODE` (default 0) on that edge, and `wrap` is 0 whenever the count is not 5.
- R2: With `rst` low, a count of 0, 1, 2, 3 or 4 becomes the count plus one at the next rising edge.
- R3: With `rst` low, a count of 5 becomes 0 at the next rising edge.
- R4: With `rst` low, bit 0 of the count inverts on every rising edge, in every state, including 6 and 7.
- R5: With `rst` low, the unused code 6 (binary 110) becomes 1 at the next rising edge.
- R6: With `rst` low, the unused code 7 (binary 111) becomes 0 at the next rising edge.
- R7: `wrap` is 1 exactly while the count equals 5.
- R8: After any rising edge with `rst` low, the count is in the range 0 to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset; loads `RESET_CODE` |
| count | output | 3 | Current state code |
| wrap | output | 1 | High while the count is 5 |

## Verification
The assertions check the following on every clock:

- each step transition and the wrap transition;
- the low-bit inversion;
- both recovery successors;
- that the code is legal after every unreset edge;
- the agreement of `wrap` with the count.

Only the bench scenarios show some other behaviours:

- that a start in an unused code rejoins the sequence and then repeats a correct period over hundreds of cycles;
- that a reset in the middle of a run returns the count to zero.

These scenarios use extra instances built with `RESET_CODE` set to 6 and to 7.

// File: rtl/modsix_pkg.sv
package modsix_pkg;

    localparam int STATE_W   = 3;
    localparam int MODULUS   = 6;
    localparam int LAST_CODE = MODULUS - 1;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO   = 3'd0,
        ST_ONE    = 3'd1,
        ST_TWO    = 3'd2,
        ST_THREE  = 3'd3,
        ST_FOUR   = 3'd4,
        ST_FIVE   = 3'd5,
        ST_SPARE6 = 3'd6,
        ST_SPARE7 = 3'd7
    } state_t;

endpackage

// File: rtl/modsix_next.sv
// Combinational next-state function of the modulo-6 counter.
module modsix_next
    import modsix_pkg::*;
(
    input  state_t cur,
    output state_t nxt
);

    always_comb begin
        unique case (cur)
            ST_ZERO:   nxt = ST_ONE;    // step
            ST_ONE:    nxt = ST_TWO;    // step
            ST_TWO:    nxt = ST_THREE;  // step
            ST_THREE:  nxt = ST_FOUR;   // step
            ST_FOUR:   nxt = ST_FIVE;   // step
            ST_FIVE:   nxt = ST_ZERO;   // wrap
            ST_SPARE6: nxt = ST_ONE;    // recovery: upper bits clear, low bit inverts
            ST_SPARE7: nxt = ST_ZERO;   // recovery: upper bits clear, low bit inverts
        endcase
    end

endmodule

// File: rtl/modsix_state_reg.sv
// One D flip-flop per state bit, with synchronous reset to a parameter code.
module modsix_state_reg #(
    parameter int          WIDTH      = 3,
    parameter logic [WIDTH-1:0] RESET_CODE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= RESET_CODE[i];
            else     q[i] <= d[i];
        end
    end

endmodule

// File: rtl/modsix_out.sv
// Output decode: the wrap flag marks the final state of each period.
module modsix_out
    import modsix_pkg::*;
(
    input  state_t cur,
    output logic   wrap
);

    always_comb begin
        unique case (cur)
            ST_FIVE: wrap = 1'b1;
            default: wrap = 1'b0;
        endcase
    end

endmodule

// File: rtl/modsix_counter.sv
module modsix_counter
    import modsix_pkg::*;
#(
    parameter logic [STATE_W-1:0] RESET_CODE = ST_ZERO
) (
    input  logic               clk,
    input  logic               rst,
    output logic [STATE_W-1:0] count,
    output logic               wrap
);

    logic [STATE_W-1:0] state_q;
    state_t             cur_state;
    state_t             nxt_state;

    assign cur_state = state_t'(state_q);

    modsix_next u_next (
        .cur (cur_state),
        .nxt (nxt_state)
    );

    modsix_state_reg #(
        .WIDTH      (STATE_W),
        .RESET_CODE (RESET_CODE)
    ) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_state),
        .q   (state_q)
    );

    modsix_out u_out (
        .cur  (cur_state),
        .wrap (wrap)
    );

    assign count = state_q;

endmodule

// File: rtl/modsix_counter_chk.sv
module modsix_counter_chk #(
    parameter logic [2:0] RESET_CODE = 3'd0
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] count,
    input logic       wrap
);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (count == RESET_CODE));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && count < 3'd5) |=> (count == $past(count) + 3'd1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && count == 3'd5) |=> (count == 3'd0));

    assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (count[0] != $past(count[0])));

    assert_spare6_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && count == 3'd6) |=> (count == 3'd1));

    assert_spare7_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && count == 3'd7) |=> (count == 3'd0));

    assert_wrap_flag_R7: assert property (@(posedge clk) disable iff (rst)
        wrap == (count == 3'd5));

    assert_legal_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (count <= 3'd5));

endmodule

bind modsix_counter modsix_counter_chk #(.RESET_CODE(RESET_CODE)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .count (count),
    .wrap  (wrap)
);

// File: tb/modsix_counter_test.sv
`timescale 1ns/1ps
module modsix_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cnt0, cnt6, cnt7;
    logic       wrp0, wrp6, wrp7;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    modsix_counter #(.RESET_CODE(3'd0)) uut (
        .clk(clk), .rst(rst), .count(cnt0), .wrap(wrp0));
    modsix_counter #(.RESET_CODE(3'd6)) uut_s6 (
        .clk(clk), .rst(rst), .count(cnt6), .wrap(wrp6));
    modsix_counter #(.RESET_CODE(3'd7)) uut_s7 (
        .clk(clk), .rst(rst), .count(cnt7), .wrap(wrp7));

    typedef struct {
        logic [2:0] p0, e0, p6, e6, p7, e7;
    } item_t;

    item_t sb_q[$];
    logic  mon_on   = 1'b0;
    logic  mon_done = 1'b0;

    // Reference successor from the requirements (R2, R3, R5, R6).
    function automatic logic [2:0] succ(input logic [2:0] c);
        if (c == 3'd6)      return 3'd1;
        else if (c == 3'd7) return 3'd0;
        else if (c == 3'd5) return 3'd0;
        else                return c + 3'd1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: pushes the expected state of every instance for n edges.
    task automatic push_run(input int n);
        logic [2:0] a = 3'd0, b = 3'd6, c = 3'd7;
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.p0 = a; it.e0 = succ(a);
            it.p6 = b; it.e6 = succ(b);
            it.p7 = c; it.e7 = succ(c);
            sb_q.push_back(it);
            a = it.e0; b = it.e6; c = it.e7;
        end
    endtask

    // Monitor: one expected item per clock, sampled at the falling edge.
    initial begin
        wait (mon_on);
        while (sb_q.size() > 0) begin
            item_t it;
            @(negedge clk);
            it = sb_q.pop_front();
            check(cnt0 == it.e0, (it.p0 == 3'd5) ? "R3" : "R2", "count",
                  int'(cnt0), int'(it.e0));
            check(cnt0[0] != it.p0[0], "R4", "bit0 toggle",
                  int'(cnt0[0]), int'(~it.p0[0]));
            check(wrp0 == (it.e0 == 3'd5), "R7", "wrap",
                  int'(wrp0), int'(it.e0 == 3'd5));
            check(cnt6 == it.e6,
                  (it.p6 == 3'd6) ? "R5" : "R8", "count(start 6)",
                  int'(cnt6), int'(it.e6));
            check(cnt7 == it.e7,
                  (it.p7 == 3'd7) ? "R6" : "R8", "count(start 7)",
                  int'(cnt7), int'(it.e7));
            check(cnt6[0] != it.p6[0], "R4", "bit0 toggle(start 6)",
                  int'(cnt6[0]), int'(~it.p6[0]));
        end
        mon_done = 1'b1;
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        push_run(600);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cnt0 == 3'd0, "R1", "reset count", int'(cnt0), 0);
        check(wrp0 == 1'b0, "R1", "reset wrap", int'(wrp0), 0);
        check(cnt6 == 3'd6, "R1", "reset code 6", int'(cnt6), 6);
        check(cnt7 == 3'd7, "R1", "reset code 7", int'(cnt7), 7);
        check(wrp6 == 1'b0, "R7", "wrap at code 6", int'(wrp6), 0);
        rst    = 1'b0;
        mon_on = 1'b1;
        wait (mon_done);
        // Mid-run reset, taken while the count is not at zero.
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(cnt0 == 3'd0, "R1", "mid-run reset count", int'(cnt0), 0);
        check(cnt7 == 3'd7, "R1", "mid-run reset code 7", int'(cnt7), 7);
        rst = 1'b0;
        @(negedge clk);
        check(cnt0 == 3'd1, "R2", "first step after reset", int'(cnt0), 1);
        check(cnt7 == 3'd0, "R6", "recovery after reset", int'(cnt7), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule